// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers the four shared PCI interrupt lines, PIRQ A through D, onto sixteen legacy interrupt-controller inputs. Every PCI function reports a level change on one of its four INTx pins together with its device/function number. The block folds slot and pin into one of the four shared lines with the usual rotating swizzle. It records the level of every pin, so that a shared line stays asserted while any of its contributors is high.

Each shared line owns one routing byte, written through a byte-wide configuration write port. A value below 16 names the controller input that receives the line. Any larger value cuts the line off. A bitmap of sixteen inputs by four lines holds the contribution of each line to each input. Every controller output is the OR of its four bitmap bits, so several lines can share one input as a wired-OR. Whenever a routing byte is written, the whole bitmap is discarded and built again from the present line levels under the new routing. The outputs are registered. A route-query port reports, for each line, whether it is enabled and which input it drives.

Top module: `pirq_router`

## Requirements
- R1: The routing bytes for lines A, B, C and D sit at configuration offsets 0x60, 0x61, 0x62 and 0x63. A write with `cfgWrEn` high stores `cfgWrData`, and `cfgRdData` returns the stored byte for the offset on `cfgAddr`. At any other offset, `cfgRdData` reads 0x00 and a write changes nothing.
- R2: Reset sets all four routing bytes to 0x80. At reset every line is disabled, `routeEnabled` is 0 and `irqOut` is 0.
- R3: An event on pin `intxPin` (0 = INTA … 3 = INTD) from slot `intxDevfn[7:3]` lands on line (pin + slot − 1) mod 4, where line 0 = A.
- R4: The level of a line is the OR of the last reported levels of all slot pins that map onto it. The line drops only when the last of those pins drops.
- R5: A line whose routing byte is 16 or more contributes to no output. A level change on such a line leaves `irqOut` unchanged.
- R6: `irqOut[i]` is the OR of all enabled lines whose routing byte equals i. Two lines routed to the same input drive it jointly.
- R7: After a routing write, the outputs are rebuilt from the present line levels. A line that is already high appears at its new input and leaves its old one. Enabling a line that is already high raises its input.
- R8: `routeEnabled[p]` is 1 exactly when the byte of line p is below 16. In that case `routeIrq[4p+3:4p]` holds that byte. Otherwise the field reads 0.
- R9: `irqOut` changes one clock after the edge that samples the event or write, and not before. With no event and no write, `irqOut` holds.
- R10: A routing write and a level event in the same cycle are both reflected in the outputs after that one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 8 | Configuration byte offset for read and write |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Byte stored at `cfgAddr` (0 outside the routing bytes) |
| intxEvt | input | 1 | Pin level change strobe |
| intxDevfn | input | 8 | Device/function number of the reporting function |
| intxPin | input | 2 | INTx pin, 0 = INTA |
| intxLevel | input | 1 | New level of that pin |
| irqOut | output | 16 | Registered interrupt-controller inputs |
| routeEnabled | output | 4 | Per line: routing is enabled |
| routeIrq | output | 16 | Per line: 4-bit routed input number |

## Verification
A routing write and a pin-level event can arrive in the same clock. The rebuild must then use both the new routing byte and the new pin level, or one of the two updates is lost. The bench provokes this by writing the byte of line D in the same cycle as raising a pin that swizzles onto D. It expects exactly input 3 one edge later, and nothing before that edge. Sequences of shared pins, shared inputs, disabled lines and re-routing of live lines are driven from a vector table. Each step is judged against hand-computed masks of `irqOut`.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
  localparam int PIRQ_COUNT = 4;
  localparam int IRQ_COUNT  = 16;
  localparam int SLOT_COUNT = 32;
  localparam int PIN_COUNT  = 4;
  localparam int BYTE_W     = 8;
  localparam int PIRQ_W     = $clog2(PIRQ_COUNT);
  localparam int IRQ_W      = $clog2(IRQ_COUNT);
  localparam int SLOT_W     = $clog2(SLOT_COUNT);
  localparam int PIN_W      = $clog2(PIN_COUNT);
  localparam int PIN_IDX_W  = SLOT_W + PIN_W;

  typedef logic [BYTE_W-1:0] routeByte_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                  rebuild;
    logic                  levelSet;
    logic [PIRQ_W-1:0]     levelPirq;
    logic [PIN_IDX_W-1:0]  pinIdx;
    logic                  levelVal;
  } ctrlStrobe_t;
endpackage

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_router_pkg::*;
#(
  parameter logic [7:0] ROUTE_BASE  = 8'h60,
  parameter logic [7:0] ROUTE_RESET = 8'h80
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                cfgWrEn,
  input  logic [BYTE_W-1:0]                   cfgAddr,
  input  logic [BYTE_W-1:0]                   cfgWrData,
  output logic [BYTE_W-1:0]                   cfgRdData,
  input  logic                                intxEvt,
  input  logic [BYTE_W-1:0]                   intxDevfn,
  input  logic [PIN_W-1:0]                    intxPin,
  input  logic                                intxLevel,
  output ctrlStrobe_t                         strobe,
  output routeByte_t [PIRQ_COUNT-1:0]         routeNext,
  output routeByte_t [PIRQ_COUNT-1:0]         routeCur
);
  routeByte_t [PIRQ_COUNT-1:0] routeRegs;
  logic [PIRQ_COUNT-1:0]       routeHit;
  logic [SLOT_W-1:0]           slotNum;
  logic [PIRQ_W-1:0]           swizzled;

  // one routing byte per shared line
  for (genvar p = 0; p < PIRQ_COUNT; p++) begin : g_route
    localparam logic [BYTE_W-1:0] OFFS = ROUTE_BASE + BYTE_W'(p);
    assign routeHit[p]  = cfgWrEn && (cfgAddr == OFFS);
    assign routeNext[p] = routeHit[p] ? cfgWrData : routeRegs[p];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) routeRegs[p] <= ROUTE_RESET;
      else       routeRegs[p] <= routeNext[p];
    end
  end

  assign routeCur = routeRegs;

  always_comb begin
    cfgRdData = '0;
    for (int p = 0; p < PIRQ_COUNT; p++) begin
      if (cfgAddr == ROUTE_BASE + BYTE_W'(p)) cfgRdData = routeRegs[p];
    end
  end

  // slot swizzle: (pin + slot - 1) mod line count
  assign slotNum  = intxDevfn[BYTE_W-1 -: SLOT_W];
  assign swizzled = PIRQ_W'(intxPin) + PIRQ_W'(slotNum) - PIRQ_W'(1);

  always_comb begin
    strobe.rebuild   = |routeHit;
    strobe.levelSet  = intxEvt;
    strobe.levelPirq = swizzled;
    strobe.pinIdx    = {slotNum, intxPin};
    strobe.levelVal  = intxLevel;
  end
endmodule

// File: rtl/pirq_datapath.sv
module pirq_datapath
  import pirq_router_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  strobe,
  input  routeByte_t [PIRQ_COUNT-1:0]  routeNext,
  output logic [IRQ_COUNT-1:0]         irqOut
);
  localparam int PIN_TOTAL = SLOT_COUNT * PIN_COUNT;
  localparam int MAP_W     = IRQ_COUNT * PIRQ_COUNT;

  logic [PIN_TOTAL-1:0]  pinLvl, pinNext;
  logic [PIRQ_COUNT-1:0] pirqLvlNext;
  logic [PIRQ_COUNT-1:0] routeOk;
  logic [MAP_W-1:0]      levelMap, levelMapNext;
  logic [IRQ_COUNT-1:0]  irqNext;

  always_comb begin
    pinNext = pinLvl;
    if (strobe.levelSet) pinNext[strobe.pinIdx] = strobe.levelVal;
  end

  // line level: OR of every slot pin that swizzles onto it
  for (genvar p = 0; p < PIRQ_COUNT; p++) begin : g_line
    always_comb begin
      pirqLvlNext[p] = 1'b0;
      for (int s = 0; s < SLOT_COUNT; s++) begin
        for (int i = 0; i < PIN_COUNT; i++) begin
          if (((i + s + PIRQ_COUNT - 1) % PIRQ_COUNT) == p)
            pirqLvlNext[p] = pirqLvlNext[p] | pinNext[s*PIN_COUNT + i];
        end
      end
    end
    assign routeOk[p] = routeNext[p] < BYTE_W'(IRQ_COUNT);
  end

  // contribution bitmap: bit (irq * lines + line)
  always_comb begin
    int idx;
    levelMapNext = levelMap;
    idx = 0;
    if (strobe.rebuild) begin
      levelMapNext = '0;
      for (int p = 0; p < PIRQ_COUNT; p++) begin
        if (routeOk[p]) begin
          idx = int'(routeNext[p][IRQ_W-1:0]) * PIRQ_COUNT + p;
          levelMapNext[idx] = pirqLvlNext[p];
        end
      end
    end else if (strobe.levelSet && routeOk[strobe.levelPirq]) begin
      idx = int'(routeNext[strobe.levelPirq][IRQ_W-1:0]) * PIRQ_COUNT
            + int'(strobe.levelPirq);
      levelMapNext[idx] = pirqLvlNext[strobe.levelPirq];
    end
  end

  for (genvar q = 0; q < IRQ_COUNT; q++) begin : g_irq
    assign irqNext[q] = |levelMapNext[q*PIRQ_COUNT +: PIRQ_COUNT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinLvl   <= '0;
      levelMap <= '0;
      irqOut   <= '0;
    end else begin
      pinLvl   <= pinNext;
      levelMap <= levelMapNext;
      irqOut   <= irqNext;
    end
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
#(
  parameter logic [7:0] ROUTE_BASE  = 8'h60,
  parameter logic [7:0] ROUTE_RESET = 8'h80
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgWrEn,
  input  logic [BYTE_W-1:0]             cfgAddr,
  input  logic [BYTE_W-1:0]             cfgWrData,
  output logic [BYTE_W-1:0]             cfgRdData,
  input  logic                          intxEvt,
  input  logic [BYTE_W-1:0]             intxDevfn,
  input  logic [PIN_W-1:0]              intxPin,
  input  logic                          intxLevel,
  output logic [IRQ_COUNT-1:0]          irqOut,
  output logic [PIRQ_COUNT-1:0]         routeEnabled,
  output logic [PIRQ_COUNT*IRQ_W-1:0]   routeIrq
);
  ctrlStrobe_t                 strobe;
  routeByte_t [PIRQ_COUNT-1:0] routeNext;
  routeByte_t [PIRQ_COUNT-1:0] routeCur;

  pirq_ctrl #(.ROUTE_BASE(ROUTE_BASE), .ROUTE_RESET(ROUTE_RESET)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData),
    .intxEvt(intxEvt), .intxDevfn(intxDevfn), .intxPin(intxPin),
    .intxLevel(intxLevel),
    .strobe(strobe), .routeNext(routeNext), .routeCur(routeCur)
  );

  pirq_datapath u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .routeNext(routeNext),
    .irqOut(irqOut)
  );

  // route query
  for (genvar p = 0; p < PIRQ_COUNT; p++) begin : g_query
    assign routeEnabled[p] = routeCur[p] < BYTE_W'(IRQ_COUNT);
    assign routeIrq[p*IRQ_W +: IRQ_W] =
      routeEnabled[p] ? routeCur[p][IRQ_W-1:0] : '0;
  end
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
  import pirq_router_pkg::*;
#(
  parameter logic [7:0] ROUTE_BASE = 8'h60
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        cfgWrEn,
  input logic [BYTE_W-1:0]           cfgAddr,
  input logic [BYTE_W-1:0]           cfgWrData,
  input logic                        intxEvt,
  input logic [IRQ_COUNT-1:0]        irqOut,
  input logic [PIRQ_COUNT-1:0]       routeEnabled,
  input logic [PIRQ_COUNT*IRQ_W-1:0] routeIrq
);
  logic [IRQ_COUNT-1:0] coverMask;

  always_comb begin
    coverMask = '0;
    for (int p = 0; p < PIRQ_COUNT; p++) begin
      if (routeEnabled[p]) coverMask[routeIrq[p*IRQ_W +: IRQ_W]] = 1'b1;
    end
  end

  assert_reset_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (routeEnabled == '0 && irqOut == '0));

  assert_out_covered_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut & ~coverMask) == '0);

  assert_disabled_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(irqOut) <= $countones(routeEnabled));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWrEn && !intxEvt) |=> $stable(irqOut));

  for (genvar p = 0; p < PIRQ_COUNT; p++) begin : g_wr
    assert_route_write_R1: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWrEn && cfgAddr == ROUTE_BASE + BYTE_W'(p)) |=>
        (routeEnabled[p] == ($past(cfgWrData) < BYTE_W'(IRQ_COUNT))));
  end
endmodule

bind pirq_router pirq_router_chk #(.ROUTE_BASE(ROUTE_BASE)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
  .cfgWrData(cfgWrData), .intxEvt(intxEvt), .irqOut(irqOut),
  .routeEnabled(routeEnabled), .routeIrq(routeIrq)
);

// File: tb/test_pirq_router.sv
`timescale 1ns/1ps
module test_pirq_router;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = 8'h00;
  logic [7:0]  cfgWrData = 8'h00;
  logic [7:0]  cfgRdData;
  logic        intxEvt = 1'b0;
  logic [7:0]  intxDevfn = 8'h00;
  logic [1:0]  intxPin = 2'd0;
  logic        intxLevel = 1'b0;
  logic [15:0] irqOut;
  logic [3:0]  routeEnabled;
  logic [15:0] routeIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pirq_router i_pirq_router (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .intxEvt(intxEvt),
    .intxDevfn(intxDevfn), .intxPin(intxPin), .intxLevel(intxLevel),
    .irqOut(irqOut), .routeEnabled(routeEnabled), .routeIrq(routeIrq)
  );

  // vector: [33] kind (0 write, 1 event) [32:25] addr/devfn [24:17] data/pin
  //         [16] level [15:0] expected irqOut
  localparam int NVEC = 15;
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b0, 8'h60, 8'h05, 1'b0, 16'h0000},
    {1'b1, 8'h08, 8'h00, 1'b1, 16'h0020},
    {1'b0, 8'h61, 8'h05, 1'b0, 16'h0020},
    {1'b1, 8'h10, 8'h03, 1'b1, 16'h0020},
    {1'b1, 8'h08, 8'h00, 1'b0, 16'h0020},
    {1'b1, 8'h10, 8'h03, 1'b0, 16'h0000},
    {1'b1, 8'h00, 8'h02, 1'b1, 16'h0020},
    {1'b1, 8'h08, 8'h00, 1'b1, 16'h0020},
    {1'b1, 8'h00, 8'h02, 1'b0, 16'h0020},
    {1'b0, 8'h60, 8'h09, 1'b0, 16'h0200},
    {1'b0, 8'h62, 8'h10, 1'b0, 16'h0200},
    {1'b1, 8'h18, 8'h00, 1'b1, 16'h0200},
    {1'b0, 8'h62, 8'h0F, 1'b0, 16'h8200},
    {1'b0, 8'h60, 8'h80, 1'b0, 16'h8000},
    {1'b1, 8'h18, 8'h00, 1'b0, 16'h0000}
  };

  function automatic string tagOf(int k);
    case (k)
      0, 2:         return "R1 route write";
      1, 3, 6:      return "R3 swizzle";
      4, 5, 14:     return "R4 shared pins";
      7, 8:         return "R6 shared input";
      10, 11:       return "R5 disabled line";
      default:      return "R7 rebuild";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic kind, logic [7:0] a, logic [7:0] b, logic lvl);
    @(negedge clk);
    if (kind) begin
      intxEvt = 1'b1; intxDevfn = a; intxPin = b[1:0]; intxLevel = lvl;
    end else begin
      cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = b;
    end
    @(negedge clk);
    cfgWrEn = 1'b0; intxEvt = 1'b0;
  endtask

  task automatic readByte(logic [7:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    cfgAddr = a;
    #1;
    check(req, 32'(cfgRdData), 32'(exp));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2 irqOut at reset", 32'(irqOut), 32'h0);
    check("R2 routeEnabled at reset", 32'(routeEnabled), 32'h0);
    rstN = 1'b1;
    for (int p = 0; p < 4; p++) readByte(8'h60 + 8'(p), 8'h80, "R2 reset byte");

    // vector walk
    for (int k = 0; k < NVEC; k++) begin
      step(VEC[k][33], VEC[k][32:25], VEC[k][24:17], VEC[k][16]);
      check(tagOf(k), 32'(irqOut), 32'(VEC[k][15:0]));
    end

    // R1 read-back and foreign offset
    readByte(8'h60, 8'h80, "R1 readback A");
    readByte(8'h61, 8'h05, "R1 readback B");
    readByte(8'h62, 8'h0F, "R1 readback C");
    readByte(8'h63, 8'h80, "R1 readback D");
    step(1'b0, 8'h64, 8'h07, 1'b0);
    readByte(8'h64, 8'h00, "R1 foreign offset read");
    check("R1 foreign write leaves irqOut", 32'(irqOut), 32'h0);
    check("R1 foreign write leaves routes", 32'(routeEnabled), 32'h6);

    // R8 route query
    check("R8 routeEnabled", 32'(routeEnabled), 32'h6);
    check("R8 routeIrq", 32'(routeIrq), 32'h0F50);

    // R9 and R10: write D and raise a D pin in the same cycle
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 8'h63; cfgWrData = 8'h03;
    intxEvt = 1'b1; intxDevfn = 8'h20; intxPin = 2'd0; intxLevel = 1'b1;
    #1;
    check("R9 no change before edge", 32'(irqOut), 32'h0);
    @(negedge clk);
    cfgWrEn = 1'b0; intxEvt = 1'b0;
    check("R10 write and event together", 32'(irqOut), 32'h0008);
    check("R10 route D enabled", 32'(routeEnabled), 32'hE);
    repeat (4) @(negedge clk);
    check("R9 idle hold", 32'(irqOut), 32'h0008);

    // R2 reset in mid-run
    rstN = 1'b0;
    #1;
    check("R2 irqOut after reset", 32'(irqOut), 32'h0);
    check("R2 routes after reset", 32'(routeEnabled), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    readByte(8'h63, 8'h80, "R2 byte after reset");

    summary();
  end
endmodule